// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit carries out a SIMD byte shuffle against a small vector register file of 32 entries, each 128 bits wide. A request names a destination register, a first table register, a table size of one to four registers and an index register. It also picks 8 or 16 result lanes and selects how out-of-range lanes are treated. The unit concatenates the table registers into a byte array of 16 to 64 bytes. Each unsigned index byte then selects one byte of that array, and the assembled vector is written back into the destination register.

Requests use a valid/ready handshake. The lookup reads the register file in the cycle the request is accepted, and the result is held for one cycle before it is written. A `done_o` pulse marks the cycle whose closing edge commits the write. A separate load port and a read port give direct access to the register file, so software or a test harness can set up tables and read results.

Top module: `vtbl_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every register reads as zero, `req_ready_o` is 1 and `done_o` is 0.
- R2: With `ld_en_i` high, the rising edge writes `ld_data_i` into register `ld_addr_i`. `rd_data_o` always shows register `rd_addr_i` combinationally.
- R3: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. In the following cycle `done_o` is 1 and `req_ready_o` is 0. The closing edge of that cycle writes the destination, and `done_o` is never high in two consecutive cycles.
- R4: Result lane i, for i from 0 upward (lane i is bits 8i+7:8i), holds table byte number `idx[i]`. Byte 0 is the least significant byte of the first table register, and each later register supplies the next 16 bytes upward.
- R5: `req_len_i` gives the table size minus one (0 means 1 register, 3 means 4 registers). An index byte is in range only when its unsigned value is below 16 times the table size.
- R6: Table register k is register (`req_tbl_i` + k) modulo 32, so register 31 is followed by register 0.
- R7: With `req_keep_i` = 0, an out-of-range lane yields 0x00.
- R8: With `req_keep_i` = 1, an out-of-range lane keeps the byte that the destination held before the request.
- R9: With `req_wide_i` = 0, only index bytes 0 to 7 are used, and result bits 127:64 are written as zero in both modes. With `req_wide_i` = 1, all 16 lanes are produced.
- R10: When a write-back and a load-port write fall on the same edge, the write-back wins.
- R11: The destination may be the same register as the index or a table register. The lookup uses the values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_dst_i | input | 5 | Destination register |
| req_tbl_i | input | 5 | First table register |
| req_len_i | input | 2 | Table size in registers, minus one |
| req_idx_i | input | 5 | Index register |
| req_wide_i | input | 1 | 1: 16 lanes, 0: 8 lanes |
| req_keep_i | input | 1 | 1: out-of-range lanes keep destination byte, 0: zero |
| ld_en_i | input | 1 | Load-port write enable |
| ld_addr_i | input | 5 | Load-port register |
| ld_data_i | input | 128 | Load-port data |
| rd_addr_i | input | 5 | Read-port register |
| rd_data_o | output | 128 | Read-port data |
| done_o | output | 1 | Write-back happens at the end of this cycle |

## Verification
The hardest state to reach is the one where the register being written also feeds the lookup. This covers a destination equal to the index or table register, a table that wraps from register 31 to 0, and a load-port write on the same edge as the write-back. Directed requests set up each of these on purpose. The bench drives the load port during the `done_o` cycle, points the table at register 31, and reuses the index register as the destination. Random requests then draw index bytes that straddle the 16, 32, 48 and 64 byte limits, so both lane paths and both out-of-range modes are exercised at each table size.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int unsigned VTBL_NREGS = 32;
  localparam int unsigned VTBL_VBYTES = 16;
  localparam int unsigned VTBL_MAXT = 4;

  typedef enum logic {
    OOB_ZERO = 1'b0,
    OOB_KEEP = 1'b1
  } oob_mode_e;
endpackage

// File: rtl/vtbl_rf.sv
module vtbl_rf #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned VBITS = 128,
  parameter int unsigned NRD   = 7,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [VBITS-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]      raddr_i,
  output logic [NRD-1:0][VBITS-1:0]   rdata_o
);
  logic [VBITS-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < int'(NREGS); r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar k = 0; k < int'(NRD); k++) begin : g_rd
    assign rdata_o[k] = mem_q[raddr_i[k]];
  end
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane #(
  parameter int unsigned TBYTES = 64,
  localparam int unsigned TIW   = $clog2(TBYTES)
) (
  input  logic [TBYTES-1:0][7:0] tbytes_i,
  input  logic [7:0]             idx_i,
  input  logic [8:0]             lim_i,
  input  logic [7:0]             old_i,
  input  logic                   active_i,
  input  logic                   keep_i,
  output logic [7:0]             byte_o
);
  logic       in_rng;
  logic [7:0] pick;

  assign in_rng = {1'b0, idx_i} < lim_i;
  assign pick   = tbytes_i[idx_i[TIW-1:0]];

  always_comb begin
    if (!active_i)    byte_o = 8'h00;
    else if (in_rng)  byte_o = pick;
    else if (keep_i)  byte_o = old_i;
    else              byte_o = 8'h00;
  end
endmodule

// File: rtl/vtbl_gather.sv
module vtbl_gather #(
  parameter int unsigned VBYTES = 16,
  parameter int unsigned MAXT   = 4,
  localparam int unsigned VBITS = VBYTES * 8,
  localparam int unsigned TBYTES = VBYTES * MAXT,
  localparam int unsigned LW    = (MAXT > 1) ? $clog2(MAXT) : 1
) (
  input  logic [MAXT-1:0][VBITS-1:0] tbl_i,
  input  logic [LW-1:0]              len_i,
  input  logic [VBITS-1:0]           idx_i,
  input  logic [VBITS-1:0]           old_i,
  input  logic                       wide_i,
  input  vtbl_pkg::oob_mode_e        mode_i,
  output logic [VBITS-1:0]           res_o
);
  logic [TBYTES-1:0][7:0] tbytes;
  logic [8:0]             lim;
  logic                   keep;

  // register 0 of the table occupies the lowest bytes
  assign tbytes = tbl_i;
  assign lim    = 9'((32'(len_i) + 1) * VBYTES);
  assign keep   = (mode_i == vtbl_pkg::OOB_KEEP);

  for (genvar l = 0; l < int'(VBYTES); l++) begin : g_lane
    logic active;
    assign active = (l < int'(VBYTES / 2)) ? 1'b1 : wide_i;

    vtbl_lane #(.TBYTES(TBYTES)) u_lane (
      .tbytes_i (tbytes),
      .idx_i    (idx_i[l*8 +: 8]),
      .lim_i    (lim),
      .old_i    (old_i[l*8 +: 8]),
      .active_i (active),
      .keep_i   (keep),
      .byte_o   (res_o[l*8 +: 8])
    );
  end
endmodule

// File: rtl/vtbl_unit.sv
module vtbl_unit #(
  parameter int unsigned NREGS  = vtbl_pkg::VTBL_NREGS,
  parameter int unsigned VBYTES = vtbl_pkg::VTBL_VBYTES,
  parameter int unsigned MAXT   = vtbl_pkg::VTBL_MAXT,
  localparam int unsigned AW    = $clog2(NREGS),
  localparam int unsigned VBITS = VBYTES * 8,
  localparam int unsigned LW    = (MAXT > 1) ? $clog2(MAXT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_dst_i,
  input  logic [AW-1:0]    req_tbl_i,
  input  logic [LW-1:0]    req_len_i,
  input  logic [AW-1:0]    req_idx_i,
  input  logic             req_wide_i,
  input  logic             req_keep_i,
  input  logic             ld_en_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [VBITS-1:0] ld_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [VBITS-1:0] rd_data_o,
  output logic             done_o
);
  localparam int unsigned P_IDX = MAXT;
  localparam int unsigned P_OLD = MAXT + 1;
  localparam int unsigned P_OBS = MAXT + 2;
  localparam int unsigned NRD   = MAXT + 3;

  logic [NRD-1:0][AW-1:0]    raddr;
  logic [NRD-1:0][VBITS-1:0] rdata;
  logic [MAXT-1:0][VBITS-1:0] tbl_regs;
  logic [VBITS-1:0]          lookup;
  logic                      accept;

  logic             wb_valid_q;
  logic [AW-1:0]    wb_dst_q;
  logic [VBITS-1:0] wb_data_q;
  logic             wb_wide_q;

  logic             rf_we;
  logic [AW-1:0]    rf_waddr;
  logic [VBITS-1:0] rf_wdata;

  // table register numbers wrap around the file
  for (genvar k = 0; k < int'(MAXT); k++) begin : g_taddr
    assign raddr[k]    = AW'((32'(req_tbl_i) + k) % NREGS);
    assign tbl_regs[k] = rdata[k];
  end
  assign raddr[P_IDX] = req_idx_i;
  assign raddr[P_OLD] = req_dst_i;
  assign raddr[P_OBS] = rd_addr_i;

  vtbl_rf #(.NREGS(NREGS), .VBITS(VBITS), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  vtbl_gather #(.VBYTES(VBYTES), .MAXT(MAXT)) u_gather (
    .tbl_i  (tbl_regs),
    .len_i  (req_len_i),
    .idx_i  (rdata[P_IDX]),
    .old_i  (rdata[P_OLD]),
    .wide_i (req_wide_i),
    .mode_i (vtbl_pkg::oob_mode_e'(req_keep_i)),
    .res_o  (lookup)
  );

  // one request in flight; no bypass needed for back-to-back reads
  assign req_ready_o = !wb_valid_q;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_q <= 1'b0;
      wb_dst_q   <= '0;
      wb_data_q  <= '0;
      wb_wide_q  <= 1'b0;
    end else begin
      wb_valid_q <= accept;
      if (accept) begin
        wb_dst_q  <= req_dst_i;
        wb_data_q <= lookup;
        wb_wide_q <= req_wide_i;
      end
    end
  end

  // write-back takes the port over the load path
  assign rf_we    = wb_valid_q || ld_en_i;
  assign rf_waddr = wb_valid_q ? wb_dst_q  : ld_addr_i;
  assign rf_wdata = wb_valid_q ? wb_data_q : ld_data_i;

  assign rd_data_o = rdata[P_OBS];
  assign done_o    = wb_valid_q;
endmodule

// File: rtl/vtbl_chk.sv
module vtbl_chk #(
  parameter int unsigned VBITS = 128,
  parameter int unsigned AW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             done_o,
  input logic             ld_en_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic [VBITS-1:0] rd_data_o,
  input logic             wb_wide_q,
  input logic [VBITS-1:0] wb_data_q
);
  p_done_after_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (done_o && !req_ready_o));

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> req_ready_o);

  p_done_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i && req_ready_o));

  p_narrow_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wb_wide_q) |-> (wb_data_q[VBITS-1:VBITS/2] == '0));

  p_rf_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !ld_en_i) |=> ($stable(rd_addr_i) -> $stable(rd_data_o)));
endmodule

bind vtbl_unit vtbl_chk #(.VBITS(VBITS), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .ld_en_i     (ld_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .wb_wide_q   (wb_wide_q),
  .wb_data_q   (wb_data_q)
);

// File: tb/tb_vtbl_unit.sv
module tb_vtbl_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [4:0]   req_dst_i = '0;
  logic [4:0]   req_tbl_i = '0;
  logic [1:0]   req_len_i = '0;
  logic [4:0]   req_idx_i = '0;
  logic         req_wide_i = 1'b0;
  logic         req_keep_i = 1'b0;
  logic         ld_en_i = 1'b0;
  logic [4:0]   ld_addr_i = '0;
  logic [127:0] ld_data_i = '0;
  logic [4:0]   rd_addr_i = '0;
  logic [127:0] rd_data_o;
  logic         done_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] model [32];

  always #2.5 clk_i = ~clk_i;

  vtbl_unit dut (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] f_expect(int dst, int tb, int len, int ix, bit wide, bit keep);
    logic [511:0] t = '0;
    logic [127:0] iv, old, r;
    int b;
    for (int k = 0; k <= len; k++) t[k*128 +: 128] = model[(tb + k) % 32];
    iv = model[ix];
    old = model[dst];
    r = '0;
    for (int i = 0; i < (wide ? 16 : 8); i++) begin
      b = int'(iv[i*8 +: 8]);
      if (b < 16 * (len + 1)) r[i*8 +: 8] = t[b*8 +: 8];
      else if (keep)          r[i*8 +: 8] = old[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic load(int a, logic [127:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_addr_i = 5'(a); ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    model[a] = d;
  endtask

  task automatic run(string tag, int dst, int tb, int len, int ix, bit wide, bit keep, bit collide);
    logic [127:0] exp;
    exp = f_expect(dst, tb, len, ix, wide, keep);
    @(negedge clk_i);
    chk("R3 ready before request", 128'(req_ready_o), 128'(1));
    req_valid_i = 1'b1; req_dst_i = 5'(dst); req_tbl_i = 5'(tb);
    req_len_i = 2'(len); req_idx_i = 5'(ix); req_wide_i = wide; req_keep_i = keep;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R3 done after accept", 128'(done_o), 128'(1));
    chk("R3 ready low while busy", 128'(req_ready_o), 128'(0));
    if (collide) begin
      ld_en_i = 1'b1; ld_addr_i = 5'(dst); ld_data_i = ~exp;
    end
    @(negedge clk_i);
    ld_en_i = 1'b0;
    chk("R3 done single cycle", 128'(done_o), 128'(0));
    model[dst] = exp;
    rd_addr_i = 5'(dst);
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  function automatic logic [127:0] f_pat(int r);
    logic [127:0] v;
    for (int j = 0; j < 16; j++) v[j*8 +: 8] = 8'((r * 16 + j) * 7 + 3);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] v;
    int s;
    s = 32'h5eed_0042;
    void'($urandom(s));
    for (int r = 0; r < 32; r++) model[r] = '0;

    repeat (3) @(negedge clk_i);
    chk("R1 ready in reset", 128'(req_ready_o), 128'(1));
    chk("R1 done in reset", 128'(done_o), 128'(0));
    rst_ni = 1'b1;
    for (int r = 0; r < 32; r += 7) begin
      @(negedge clk_i);
      rd_addr_i = 5'(r);
      #1 chk("R1 register cleared", rd_data_o, '0);
    end
    chk("R1 ready after reset", 128'(req_ready_o), 128'(1));

    for (int r = 0; r < 32; r++) load(r, f_pat(r));
    for (int r = 0; r < 32; r += 5) begin
      rd_addr_i = 5'(r);
      #1 chk("R2 load readback", rd_data_o, f_pat(r));
    end

    // R4 / R5: two-register table, indices across both registers
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(i * 2 + 1);
    load(20, v);
    run("R4 two-register lookup", 21, 2, 1, 20, 1'b1, 1'b0, 1'b0);

    // R5 boundaries: size 1 limit 16, size 4 limit 64
    v = '0;
    v[7:0] = 8'd15; v[15:8] = 8'd16; v[23:16] = 8'd0; v[31:24] = 8'd255;
    load(22, v);
    run("R5 one-register limit", 23, 4, 0, 22, 1'b1, 1'b0, 1'b0);
    v[7:0] = 8'd63; v[15:8] = 8'd64; v[23:16] = 8'd48; v[31:24] = 8'd47;
    load(22, v);
    run("R5 four-register limit", 23, 4, 3, 22, 1'b1, 1'b0, 1'b0);

    // R7 zero and R8 keep on out-of-range lanes
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = (i % 2 == 0) ? 8'(i) : 8'(32 + i);
    load(24, v);
    load(25, f_pat(9));
    run("R7 out of range zeroed", 25, 6, 1, 24, 1'b1, 1'b0, 1'b0);
    load(25, f_pat(9));
    run("R8 out of range keeps old", 25, 6, 1, 24, 1'b1, 1'b1, 1'b0);

    // R6 wrap 31 -> 0 -> 1
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(i * 3);
    load(10, v);
    run("R6 table wraps at 31", 11, 31, 2, 10, 1'b1, 1'b0, 1'b0);

    // R9 narrow mode, upper index bytes in range but ignored
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(15 - i);
    load(12, v);
    load(13, f_pat(3));
    run("R9 narrow zero mode", 13, 0, 0, 12, 1'b0, 1'b0, 1'b0);
    load(13, f_pat(3));
    run("R9 narrow keep mode", 13, 0, 0, 12, 1'b0, 1'b1, 1'b0);

    // R10 load port collides with write-back
    run("R10 write-back beats load", 14, 0, 3, 12, 1'b1, 1'b0, 1'b1);

    // R11 destination is index, then destination is first table register
    run("R11 dst equals index reg", 12, 5, 1, 12, 1'b1, 1'b1, 1'b0);
    run("R11 dst equals table reg", 5, 5, 0, 10, 1'b1, 1'b0, 1'b0);

    // constrained random
    for (int n = 0; n < 150; n++) begin
      int ix, dst;
      ix = int'($urandom_range(0, 31));
      dst = int'($urandom_range(0, 31));
      for (int i = 0; i < 16; i++)
        v[i*8 +: 8] = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(64, 255))
                                                   : 8'($urandom_range(0, 70));
      load(ix, v);
      run("R4 random lookup", dst, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
          ix, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule